// File: doc/BRIEF.md
# Coherence-State-Aware Victim Controller for One Cache Set

This block owns the tag and coherence state of a single eight-way set in a set-associative cache. Each line carries a 2-bit coherence state: Invalid, Shared, Exclusive or Modified. The block resolves lookup/fill requests and single-line flush requests. When a fill misses, it chooses a victim way. When a line is evicted or flushed, it decides whether the whole line must go to the next level on a writeback channel or can be dropped without a transfer.

The line data lives in a separate data array. The writeback channel names the way and tag, and the data array streams the full line from there. Eviction and invalidation act on whole lines only; no request touches part of a line.

The `mode_noninc` input selects how the next level is treated:
- With `mode_noninc` low (inclusive), only Modified victims are written back.
- With `mode_noninc` high (non-inclusive), clean valid victims are also sent, because the next level may not hold a copy.

Top module: `victim_set_ctrl`

## Requirements
- R1: After reset, every way is Invalid, `wb_valid` and `done` are low, and `req_ready` is high.
- R2: A fill miss goes to the lowest-numbered Invalid way when one exists, and `done_way` reports that way.
- R3: With no Invalid way, the victim comes from a binary pseudo-LRU tree over the ways, and every fill or hit marks its way most recently used. After ways 0..7 are filled in order, successive misses pick ways 0, 4, 2, 6.
- R4: A Modified victim is offered on the writeback channel with its tag and way and `wb_dirty`=1 before its way is refilled.
- R5: In inclusive mode (`mode_noninc`=0), an Exclusive or Shared victim is dropped with no writeback.
- R6: In non-inclusive mode (`mode_noninc`=1), an Exclusive or Shared victim is written back with `wb_dirty`=0.
- R7: While `wb_valid` is high and `wb_ready` is low, `wb_valid`, `wb_tag` and `wb_way` hold steady, and `done` stays low. The transfer completes only on a cycle where `wb_valid` and `wb_ready` are both high.
- R8: A flush that hits invalidates the line. The line is first written back under the same state and mode rules as a victim, so a later lookup of that tag misses.
- R9: A flush whose tag is absent completes one cycle after acceptance, with no writeback and no state change.
- R10: Each accepted request yields exactly one single-cycle `done` pulse. The pulse comes one cycle after acceptance when no writeback is needed, and otherwise one cycle after the writeback handshake.
- R11: A read fill installs the line as Exclusive (state code 2) and a write fill as Modified (code 3). A write hit turns the line Modified. A hit completes with `done_hit`=1 and the hit way in `done_way`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mode_noninc | input | 1 | 1 = non-inclusive next level, 0 = inclusive |
| req_valid | input | 1 | Lookup/fill request (has priority over flush) |
| req_write | input | 1 | Request is a write |
| req_tag | input | TAG_W | Tag of the requested line |
| req_ready | output | 1 | Block idle; a request or flush is accepted this cycle |
| flush_valid | input | 1 | Flush request for one line |
| flush_tag | input | TAG_W | Tag of the line to flush |
| wb_valid | output | 1 | Writeback offered |
| wb_ready | input | 1 | Next level accepts the writeback |
| wb_tag | output | TAG_W | Tag of the line written back |
| wb_way | output | log2(WAYS) | Way holding the line to stream out |
| wb_dirty | output | 1 | 1 if the line was Modified |
| done | output | 1 | Request completed (one-cycle pulse) |
| done_hit | output | 1 | Completed request was a lookup hit |
| done_way | output | log2(WAYS) | Way filled, hit or flushed |

## Verification
The assertions assume that `mode_noninc` does not change while a request is in flight. They also assume the set never holds two valid lines with the same tag, which holds because a tag is filled only after a lookup miss. The stimulus changes the mode only between completed requests. It issues a new request only after the previous `done`, and it holds `wb_ready` low for several cycles on some writebacks to exercise the stall rule.

// File: rtl/vsc_pkg.sv
package vsc_pkg;
    typedef enum logic [1:0] {
        MESI_I = 2'd0,
        MESI_S = 2'd1,
        MESI_E = 2'd2,
        MESI_M = 2'd3
    } mesi_e;

    typedef enum logic [0:0] {
        PH_IDLE = 1'b0,
        PH_WB   = 1'b1
    } phase_e;
endpackage

// File: rtl/vsc_lowest.sv
module vsc_lowest #(
    parameter int N  = 8,
    localparam int IW = $clog2(N)
) (
    input  logic [N-1:0]  mask_i,
    output logic [IW-1:0] idx_o,
    output logic          any_o
);
    always_comb begin
        idx_o = '0;
        any_o = |mask_i;
        for (int i = N - 1; i >= 0; i--) begin
            if (mask_i[i]) idx_o = IW'(i);
        end
    end
endmodule

// File: rtl/vsc_plru.sv
module vsc_plru #(
    parameter int WAYS = 8,
    localparam int IW  = $clog2(WAYS)
) (
    input  logic [WAYS-1:0] bits_i,
    input  logic [IW-1:0]   touch_i,
    output logic [IW-1:0]   victim_o,
    output logic [WAYS-1:0] bits_o
);
    // Heap-ordered tree: node 1 is the root, children of n are 2n and 2n+1.
    // A node bit points toward the less recently used half.
    always_comb begin
        int node;
        node = 1;
        for (int lvl = 0; lvl < IW; lvl++) begin
            node = 2 * node + int'(bits_i[node]);
        end
        victim_o = IW'(node - WAYS);
    end

    always_comb begin
        int path;
        int nd;
        int dir;
        bits_o = bits_i;
        path   = WAYS + int'(touch_i);
        for (int lvl = 0; lvl < IW; lvl++) begin
            nd  = path >> (IW - lvl);
            dir = (path >> (IW - 1 - lvl)) & 1;
            bits_o[nd] = (dir == 0);
        end
    end
endmodule

// File: rtl/victim_set_ctrl.sv
module victim_set_ctrl
    import vsc_pkg::*;
#(
    parameter int WAYS  = 8,
    parameter int TAG_W = 8,
    localparam int IW   = $clog2(WAYS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             mode_noninc,
    input  logic             req_valid,
    input  logic             req_write,
    input  logic [TAG_W-1:0] req_tag,
    output logic             req_ready,
    input  logic             flush_valid,
    input  logic [TAG_W-1:0] flush_tag,
    output logic             wb_valid,
    input  logic             wb_ready,
    output logic [TAG_W-1:0] wb_tag,
    output logic [IW-1:0]    wb_way,
    output logic             wb_dirty,
    output logic             done,
    output logic             done_hit,
    output logic [IW-1:0]    done_way
);
    typedef struct packed {
        phase_e                       phase;
        mesi_e [WAYS-1:0]             st;
        logic  [WAYS-1:0][TAG_W-1:0]  tag;
        logic  [WAYS-1:0]             plru;
        logic                         op_fill;
        logic                         op_write;
        logic  [TAG_W-1:0]            op_tag;
        logic  [IW-1:0]               op_way;
        logic                         done;
        logic                         done_hit;
        logic  [IW-1:0]               done_way;
    } regs_t;

    regs_t r_q, r_d;

    logic [TAG_W-1:0] look_tag;
    logic [WAYS-1:0]  hit_vec, inv_vec;
    logic [IW-1:0]    hit_way, inv_way, plru_victim, fill_way, touch_way;
    logic             hit_any, inv_any;
    logic [WAYS-1:0]  plru_next;

    assign look_tag = req_valid ? req_tag : flush_tag;

    for (genvar w = 0; w < WAYS; w++) begin : g_cmp
        assign hit_vec[w] = (r_q.st[w] != MESI_I) && (r_q.tag[w] == look_tag);
        assign inv_vec[w] = (r_q.st[w] == MESI_I);
    end

    vsc_lowest #(.N(WAYS)) hit_enc_i (.mask_i(hit_vec), .idx_o(hit_way), .any_o(hit_any));
    vsc_lowest #(.N(WAYS)) inv_enc_i (.mask_i(inv_vec), .idx_o(inv_way), .any_o(inv_any));

    assign fill_way = inv_any ? inv_way : plru_victim;

    always_comb begin
        if (r_q.phase == PH_WB) touch_way = r_q.op_way;
        else if (hit_any)       touch_way = hit_way;
        else                    touch_way = fill_way;
    end

    vsc_plru #(.WAYS(WAYS)) plru_i (
        .bits_i  (r_q.plru),
        .touch_i (touch_way),
        .victim_o(plru_victim),
        .bits_o  (plru_next)
    );

    function automatic logic must_send(mesi_e s, logic noninc);
        return (s == MESI_M) || (noninc && (s != MESI_I));
    endfunction

    always_comb begin
        logic             apply;
        logic             a_fill;
        logic             a_write;
        logic [IW-1:0]    a_way;
        logic [TAG_W-1:0] a_tag;

        r_d        = r_q;
        r_d.done     = 1'b0;
        r_d.done_hit = 1'b0;
        apply   = 1'b0;
        a_fill  = r_q.op_fill;
        a_write = r_q.op_write;
        a_way   = r_q.op_way;
        a_tag   = r_q.op_tag;

        case (r_q.phase)
            PH_IDLE: begin
                if (req_valid) begin
                    if (hit_any) begin
                        r_d.done     = 1'b1;
                        r_d.done_hit = 1'b1;
                        r_d.done_way = hit_way;
                        r_d.plru     = plru_next;
                        if (req_write) r_d.st[hit_way] = MESI_M;
                    end else begin
                        a_fill  = 1'b1;
                        a_write = req_write;
                        a_way   = fill_way;
                        a_tag   = req_tag;
                        if (must_send(r_q.st[fill_way], mode_noninc)) r_d.phase = PH_WB;
                        else                                          apply     = 1'b1;
                    end
                end else if (flush_valid) begin
                    if (hit_any) begin
                        a_fill  = 1'b0;
                        a_write = 1'b0;
                        a_way   = hit_way;
                        a_tag   = flush_tag;
                        if (must_send(r_q.st[hit_way], mode_noninc)) r_d.phase = PH_WB;
                        else                                         apply     = 1'b1;
                    end else begin
                        r_d.done     = 1'b1;
                        r_d.done_way = '0;
                    end
                end
            end
            default: begin
                if (wb_ready) begin
                    apply     = 1'b1;
                    r_d.phase = PH_IDLE;
                end
            end
        endcase

        r_d.op_fill  = a_fill;
        r_d.op_write = a_write;
        r_d.op_way   = a_way;
        r_d.op_tag   = a_tag;

        if (apply) begin
            if (a_fill) begin
                r_d.tag[a_way] = a_tag;
                r_d.st[a_way]  = a_write ? MESI_M : MESI_E;
                r_d.plru       = plru_next;
            end else begin
                r_d.st[a_way]  = MESI_I;
            end
            r_d.done     = 1'b1;
            r_d.done_way = a_way;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_q.phase    <= PH_IDLE;
            for (int w = 0; w < WAYS; w++) begin
                r_q.st[w]  <= MESI_I;
                r_q.tag[w] <= '0;
            end
            r_q.plru     <= '0;
            r_q.op_fill  <= 1'b0;
            r_q.op_write <= 1'b0;
            r_q.op_tag   <= '0;
            r_q.op_way   <= '0;
            r_q.done     <= 1'b0;
            r_q.done_hit <= 1'b0;
            r_q.done_way <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    assign req_ready = (r_q.phase == PH_IDLE);
    assign wb_valid  = (r_q.phase == PH_WB);
    assign wb_tag    = r_q.tag[r_q.op_way];
    assign wb_way    = r_q.op_way;
    assign wb_dirty  = (r_q.st[r_q.op_way] == MESI_M);
    assign done      = r_q.done;
    assign done_hit  = r_q.done_hit;
    assign done_way  = r_q.done_way;
endmodule

// File: rtl/vsc_victim_chk.sv
module vsc_victim_chk #(
    parameter int WAYS  = 8,
    parameter int TAG_W = 8,
    localparam int IW   = $clog2(WAYS)
) (
    input logic             clk,
    input logic             rst_n,
    input logic             mode_noninc,
    input logic             req_ready,
    input logic             wb_valid,
    input logic             wb_ready,
    input logic [TAG_W-1:0] wb_tag,
    input logic [IW-1:0]    wb_way,
    input logic             wb_dirty,
    input logic             done,
    input logic             done_hit
);
    a_r7_wb_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (wb_valid && !wb_ready) |=> (wb_valid && $stable(wb_tag) && $stable(wb_way)));

    a_r7_no_done_while_pending: assert property (@(posedge clk) disable iff (!rst_n)
        wb_valid |-> !done);

    a_r10_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    a_r10_done_after_handshake: assert property (@(posedge clk) disable iff (!rst_n)
        (wb_valid && wb_ready) |=> (done && !wb_valid));

    a_r1_idle_no_wb: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |-> !wb_valid);

    a_r5_clean_only_noninc: assert property (@(posedge clk) disable iff (!rst_n)
        (wb_valid && !wb_dirty) |-> mode_noninc);

    a_r11_hit_no_wb: assert property (@(posedge clk) disable iff (!rst_n)
        done_hit |-> (done && $past(req_ready)));
endmodule

bind victim_set_ctrl vsc_victim_chk #(.WAYS(WAYS), .TAG_W(TAG_W)) chk_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .mode_noninc(mode_noninc),
    .req_ready  (req_ready),
    .wb_valid   (wb_valid),
    .wb_ready   (wb_ready),
    .wb_tag     (wb_tag),
    .wb_way     (wb_way),
    .wb_dirty   (wb_dirty),
    .done       (done),
    .done_hit   (done_hit)
);

// File: tb/victim_set_ctrl_tb_top.sv
module victim_set_ctrl_tb_top;
    localparam int WAYS  = 8;
    localparam int TAG_W = 8;
    localparam int IW    = 3;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             mode_noninc = 1'b0;
    logic             req_valid = 1'b0;
    logic             req_write = 1'b0;
    logic [TAG_W-1:0] req_tag = '0;
    logic             req_ready;
    logic             flush_valid = 1'b0;
    logic [TAG_W-1:0] flush_tag = '0;
    logic             wb_valid;
    logic             wb_ready = 1'b0;
    logic [TAG_W-1:0] wb_tag;
    logic [IW-1:0]    wb_way;
    logic             wb_dirty;
    logic             done;
    logic             done_hit;
    logic [IW-1:0]    done_way;

    int n_cmp = 0;
    int n_bad = 0;
    int cycles = 0;

    always #5 clk = ~clk;

    victim_set_ctrl #(.WAYS(WAYS), .TAG_W(TAG_W)) dut_i (
        .clk(clk), .rst_n(rst_n), .mode_noninc(mode_noninc),
        .req_valid(req_valid), .req_write(req_write), .req_tag(req_tag),
        .req_ready(req_ready), .flush_valid(flush_valid), .flush_tag(flush_tag),
        .wb_valid(wb_valid), .wb_ready(wb_ready), .wb_tag(wb_tag),
        .wb_way(wb_way), .wb_dirty(wb_dirty), .done(done),
        .done_hit(done_hit), .done_way(done_way)
    );

    // Observations of the last operation
    logic          o_wb;
    logic [7:0]    o_wb_tag;
    logic          o_wb_dirty;
    logic [IW-1:0] o_wb_way;
    logic [IW-1:0] o_way;
    logic          o_hit;
    int            o_lat;
    int            o_pulses;
    logic          o_stall_bad;

    task automatic check(string req, int act, int exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // kind: 0 = lookup/fill, 1 = flush. hold = cycles wb_ready stays low.
    task automatic run_op(int kind, logic [7:0] tag, logic wr, int hold);
        int waited;
        logic [7:0] first_tag;
        @(negedge clk);
        if (kind == 0) begin
            req_valid = 1'b1; req_tag = tag; req_write = wr;
        end else begin
            flush_valid = 1'b1; flush_tag = tag;
        end
        @(posedge clk);
        @(negedge clk);
        req_valid = 1'b0; flush_valid = 1'b0;
        o_wb = 1'b0; o_hit = 1'b0; o_lat = 0; o_pulses = 0;
        o_stall_bad = 1'b0; waited = 0; first_tag = '0;
        for (int c = 1; c < 40; c++) begin
            if (wb_valid) begin
                if (!o_wb) first_tag = wb_tag;
                else if (wb_tag != first_tag) o_stall_bad = 1'b1;
                o_wb = 1'b1; o_wb_tag = wb_tag; o_wb_dirty = wb_dirty; o_wb_way = wb_way;
                if (done) o_stall_bad = 1'b1;
                if (waited >= hold) wb_ready = 1'b1;
                waited++;
            end
            if (done) begin
                o_pulses++; o_way = done_way; o_hit = done_hit; o_lat = c;
                wb_ready = 1'b0;
                @(negedge clk);
                if (done) o_pulses++;
                break;
            end
            @(negedge clk);
        end
        wb_ready = 1'b0;
    endtask

    initial begin
        while (1) begin
            @(posedge clk);
            cycles++;
            if (cycles > 20000) begin
                n_bad++;
                $display("FAIL watchdog: actual %0d expected below %0d", cycles, 20000);
                $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
                $finish;
            end
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R1: reset state
        check("R1 wb_valid", int'(wb_valid), 0);
        check("R1 done", int'(done), 0);
        check("R1 req_ready", int'(req_ready), 1);
        rst_n = 1'b1;

        // R2/R11: fill into empty set; ways 0 and 3 written (Modified), rest read (Exclusive)
        for (int i = 0; i < WAYS; i++) begin
            run_op(0, 8'(10 + i), (i == 0 || i == 3), 0);
            check("R2 fill way", int'(o_way), i);
            check("R2 no wb on empty way", int'(o_wb), 0);
            check("R10 fill latency", o_lat, 1);
            check("R10 pulses", o_pulses, 1);
            check("R11 miss not hit", int'(o_hit), 0);
        end

        // R3/R4/R7: full set, pLRU picks way 0 (tag 10, Modified); stall ready 3 cycles
        run_op(0, 8'd20, 1'b0, 3);
        check("R4 wb seen", int'(o_wb), 1);
        check("R4 wb tag", int'(o_wb_tag), 10);
        check("R4 wb dirty", int'(o_wb_dirty), 1);
        check("R3 victim way 0", int'(o_way), 0);
        check("R7 stall stable", int'(o_stall_bad), 0);
        check("R7 done after handshake", o_lat, 5);
        check("R10 pulses", o_pulses, 1);

        // R3/R5: next victim way 4 (tag 14, Exclusive), inclusive -> silent drop
        run_op(0, 8'd21, 1'b0, 0);
        check("R3 victim way 4", int'(o_way), 4);
        check("R5 clean dropped", int'(o_wb), 0);
        check("R10 latency", o_lat, 1);

        // R6: non-inclusive, victim way 2 (tag 12, Exclusive) is sent clean
        mode_noninc = 1'b1;
        run_op(0, 8'd22, 1'b0, 1);
        check("R3 victim way 2", int'(o_way), 2);
        check("R6 clean wb seen", int'(o_wb), 1);
        check("R6 wb tag", int'(o_wb_tag), 12);
        check("R6 wb dirty", int'(o_wb_dirty), 0);
        run_op(0, 8'd23, 1'b0, 0);
        check("R3 victim way 6", int'(o_way), 6);
        check("R6 clean wb way", int'(o_wb_way), 6);
        mode_noninc = 1'b0;

        // R8: flush Modified tag 13 in way 3
        run_op(1, 8'd13, 1'b0, 2);
        check("R8 flush wb", int'(o_wb), 1);
        check("R8 flush wb tag", int'(o_wb_tag), 13);
        check("R8 flush dirty", int'(o_wb_dirty), 1);
        check("R8 flush way", int'(o_way), 3);
        // R9: same tag again is now absent
        run_op(1, 8'd13, 1'b0, 0);
        check("R9 miss no wb", int'(o_wb), 0);
        check("R9 miss latency", o_lat, 1);
        check("R10 pulses", o_pulses, 1);
        // R8/R5: clean flush in inclusive mode: no wb
        run_op(1, 8'd11, 1'b0, 0);
        check("R8 clean flush no wb", int'(o_wb), 0);
        check("R8 clean flush way", int'(o_way), 1);
        // R8/R2: tag 11 misses; lowest invalid of {1,3} is way 1
        run_op(0, 8'd11, 1'b0, 0);
        check("R8 invalidated misses", int'(o_hit), 0);
        check("R2 lowest invalid", int'(o_way), 1);

        // R11: read hit and write hit on tag 15 (way 5)
        run_op(0, 8'd15, 1'b0, 0);
        check("R11 hit", int'(o_hit), 1);
        check("R11 hit way", int'(o_way), 5);
        check("R11 hit no wb", int'(o_wb), 0);
        run_op(0, 8'd15, 1'b1, 0);
        run_op(1, 8'd15, 1'b0, 0);
        check("R11 write hit made Modified", int'(o_wb_dirty), 1);
        check("R11 wb after write hit", int'(o_wb), 1);

        // R6/R8: non-inclusive flush of clean tag 17 (way 7)
        mode_noninc = 1'b1;
        run_op(1, 8'd17, 1'b0, 0);
        check("R6 clean flush wb", int'(o_wb), 1);
        check("R6 clean flush dirty", int'(o_wb_dirty), 0);
        check("R8 flush way 7", int'(o_way), 7);
        mode_noninc = 1'b0;

        // R9: flush miss changes nothing: tag 16 still hits in way 6? (way 6 holds 23)
        run_op(1, 8'd99, 1'b0, 0);
        run_op(0, 8'd23, 1'b0, 0);
        check("R9 state kept", int'(o_hit), 1);
        check("R9 state kept way", int'(o_way), 6);

        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule